// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block is the programming-mode controller for an on-chip code flash that is driven through parallel pins. An external programmer presents an address, a data byte and a two-bit mode code, raises the high-voltage enable flag and strobes an active-low program input. The controller then runs the requested action on its own. A byte write is timed by an internal counter. A chip erase needs the program input held low for a configured time. Verify reads and signature reads return data without any timing.

While a write runs, the programmer can poll in two ways. It can watch the `ready` output, or it can read back the byte being written, which comes back with bit 7 inverted until the write has finished. Writes can only clear bits, so a byte that is not blank needs a chip erase before it can take a new value. A lock input blocks verify read-back. Strobes that arrive while a write is in progress are discarded and reported on `err`. The array is 4 KB by default, set by `ADDR_W`. The write and erase durations are cycle counts, given by `WRITE_CYCLES` and `ERASE_CYCLES`.

Mode codes on `mode`:
- 00: verify read
- 01: byte program
- 10: chip erase
- 11: signature read

Top module: `flash_prog_seq`

## Requirements
- R1: During reset and right after it, `ready` is 1 and `err` is 0.
- R2: A program strobe starts a byte write when all of these hold: a 1-to-0 transition of `prog_n` seen at a clock edge, `mode`=01, `hv_en`=1 and `ready`=1. From the following cycle, `ready` is 0 for exactly `WRITE_CYCLES` cycles. Address and data are captured at the strobe edge.
- R3: When a write completes, the stored byte becomes the old byte AND the captured data. Programming only clears bits.
- R4: While a write is busy, a verify read (`mode`=00, `lock_on`=0) of the captured address returns the captured data with bit 7 inverted. Verify reads of other addresses return the array contents.
- R5: From the first cycle after the write completes, a verify read returns the true stored byte.
- R6: A falling edge of `prog_n` with `hv_en`=0, or in a mode other than 01, changes neither `ready` nor the array.
- R7: A program strobe that arrives while busy is ignored. The write in progress keeps its address, data and timing, and `err` is 1 for the single following cycle.
- R8: In mode 10 with `hv_en`=1, holding `prog_n` low for `ERASE_CYCLES` consecutive clock edges while ready sets every byte to FFH. A shorter hold changes nothing.
- R9: Signature mode returns fixed values: 1EH at 030H, 51H at 031H, and 00H at any other address. At 032H it returns FFH when `sig_5v`=0 and 05H when `sig_5v`=1.
- R10: With `lock_on`=1, verify reads return 00H.
- R11: In modes 01 and 10, `dout` is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | Operation code (00 verify, 01 program, 10 erase, 11 signature) |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data byte to program |
| prog_n | input | 1 | Active-low program strobe / erase hold input |
| hv_en | input | 1 | High-voltage programming enable |
| sig_5v | input | 1 | Selects the 5 V signature code at 032H |
| lock_on | input | 1 | Lock bits programmed: verify read-back inhibited |
| dout | output | DATA_W | Read data (verify, polling, signature) |
| ready | output | 1 | 1 = ready, 0 = byte write busy |
| err | output | 1 | One-cycle flag for a strobe ignored while busy |

## Verification
The bench targets the edges of the write window. If the busy count were off by one, `ready` would return a cycle early or late. If the polling complement were applied to the wrong byte or bit, polled reads would disagree with the model. It reprograms a non-blank byte: a design that overwrote instead of ANDing would read back F0H in place of 50H. It strobes again during a busy write: a design that restarted or re-captured would move the completion time or store to the wrong address. It also releases an erase hold just short of the limit, where a premature erase would wipe the earlier byte. Finally, it covers ignored strobes with the high voltage off or in verify mode, both signature codes, and the lock inhibit.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [1:0] {
    MD_VERIFY  = 2'b00,
    MD_PROGRAM = 2'b01,
    MD_ERASE   = 2'b10,
    MD_SIGN    = 2'b11
  } fp_mode_e;

  localparam int unsigned SIG_AT_MFR  = 'h030;
  localparam int unsigned SIG_AT_DEV  = 'h031;
  localparam int unsigned SIG_AT_VPP  = 'h032;

  localparam logic [7:0] SIG_MFR_CODE = 8'h1E;
  localparam logic [7:0] SIG_DEV_CODE = 8'h51;
  localparam logic [7:0] SIG_HV_CODE  = 8'hFF;
  localparam logic [7:0] SIG_LV_CODE  = 8'h05;

endpackage

// File: rtl/flash_wr_timer.sv
module flash_wr_timer #(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_n,
  input  logic              prog_mode,
  input  logic              hv_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              err
);

  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic          prog_q;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          strobe;
  logic          load;

  always_comb begin
    strobe = prog_q & ~prog_n & prog_mode & hv_en;
    load   = strobe & ~busy_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    wr_en  = 1'b0;
    err_d  = strobe & busy_q;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        wr_en  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (load) begin
      busy_d = 1'b1;
      cnt_d  = CW'(WRITE_CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
    end else begin
      prog_q <= prog_n;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      if (load) begin
        waddr <= addr;
        wdata <= din;
      end
    end
  end

  assign busy = busy_q;
  assign err  = err_q;

  a_r2_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(strobe));

  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

  a_r7_err_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(busy_q));

  a_r7_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && busy_d) |=> ($stable(waddr) && $stable(wdata)));

endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int ERASE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic erase_mode,
  input  logic hv_en,
  input  logic prog_n,
  input  logic busy,
  output logic erase_en
);

  localparam int EW = $clog2(ERASE_CYCLES + 1);

  logic          hold;
  logic [EW-1:0] cnt_q, cnt_d;

  always_comb begin
    hold     = erase_mode & hv_en & ~prog_n & ~busy;
    erase_en = hold && (cnt_q == EW'(ERASE_CYCLES - 1));
    if (!hold || erase_en) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r8_hold_run: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_en && ERASE_CYCLES > 1) |-> $past(hold));

endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              erase_en,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] cur_w;

  always_ff @(posedge clk) begin
    if (erase_en) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[waddr] <= cur_w & wdata;
    end
  end

  assign cur_w = mem[waddr];
  assign rdata = mem[raddr];

  a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase_en) |=> ((mem[$past(waddr)] & ~$past(cur_w)) == '0));

  a_r8_erase_fill: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> (mem[0] == '1 && mem[DEPTH-1] == '1));

endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  fp_mode_e          mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              busy,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lock_on,
  input  logic              sig_5v,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] polled;

  always_comb begin
    polled = wdata;
    polled[DATA_W-1] = ~wdata[DATA_W-1];
    dout = '0;
    unique case (mode)
      MD_VERIFY: begin
        if (lock_on)                    dout = '0;
        else if (busy && addr == waddr) dout = polled;
        else                            dout = arr_rdata;
      end
      MD_SIGN: begin
        if (addr == ADDR_W'(SIG_AT_MFR))      dout = DATA_W'(SIG_MFR_CODE);
        else if (addr == ADDR_W'(SIG_AT_DEV)) dout = DATA_W'(SIG_DEV_CODE);
        else if (addr == ADDR_W'(SIG_AT_VPP))
          dout = sig_5v ? DATA_W'(SIG_LV_CODE) : DATA_W'(SIG_HV_CODE);
        else                                  dout = '0;
      end
      default: dout = '0;
    endcase
  end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 150,
  parameter int ERASE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              prog_n,
  input  logic              hv_en,
  input  logic              sig_5v,
  input  logic              lock_on,
  output logic [DATA_W-1:0] dout,
  output logic              ready,
  output logic              err
);

  logic              rst_s1, rst_core_n;
  fp_mode_e          mode_e;
  logic              busy, wr_en, erase_en;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata, arr_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_core_n <= rst_s1;
    end
  end

  assign mode_e = fp_mode_e'(mode);

  flash_wr_timer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_wr (
    .clk(clk), .rst_n(rst_core_n), .prog_n(prog_n),
    .prog_mode(mode_e == MD_PROGRAM), .hv_en(hv_en),
    .addr(addr), .din(din), .busy(busy), .wr_en(wr_en),
    .waddr(waddr), .wdata(wdata), .err(err)
  );

  flash_erase_timer #(
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_er (
    .clk(clk), .rst_n(rst_core_n), .erase_mode(mode_e == MD_ERASE),
    .hv_en(hv_en), .prog_n(prog_n), .busy(busy), .erase_en(erase_en)
  );

  flash_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_arr (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .waddr(waddr),
    .wdata(wdata), .erase_en(erase_en), .raddr(addr), .rdata(arr_rdata)
  );

  flash_rd_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rd (
    .mode(mode_e), .addr(addr), .arr_rdata(arr_rdata), .busy(busy),
    .waddr(waddr), .wdata(wdata), .lock_on(lock_on), .sig_5v(sig_5v),
    .dout(dout)
  );

  assign ready = ~busy;

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_core_n |-> (ready && !err));

endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;

  localparam int WC = 20;
  localparam int EC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [1:0] mode = 2'b11;
  logic [11:0] addr = '0;
  logic [7:0] din = '0;
  logic       prog_n = 1'b1;
  logic       hv_en = 1'b0;
  logic       sig_5v = 1'b0;
  logic       lock_on = 1'b0;
  logic [7:0] dout;
  logic       ready, err;

  always #5 clk = ~clk;

  flash_prog_seq #(.WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .din(din),
    .prog_n(prog_n), .hv_en(hv_en), .sig_5v(sig_5v), .lock_on(lock_on),
    .dout(dout), .ready(ready), .err(err)
  );

  int    vectors = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    chk_on = 0;
  bit    done = 0;

  // behavioural reference state
  bit         m_busy, m_prev, m_err, mknown;
  int         m_cnt, m_ehold;
  logic [11:0] m_wa;
  logic [7:0] m_wd;
  logic [7:0] mm [0:4095];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_prev = 1; m_ehold = 0; m_err = 0;
    end else begin
      bit pulse, was_busy;
      was_busy = m_busy;
      pulse = m_prev && !prog_n && mode == 2'b01 && hv_en;
      m_err = pulse && was_busy;
      if (was_busy) begin
        if (m_cnt == 0) begin
          mm[m_wa] = mm[m_wa] & m_wd;
          m_busy = 0;
        end else m_cnt--;
      end else if (pulse) begin
        m_busy = 1; m_cnt = WC - 1; m_wa = addr; m_wd = din;
      end
      if (!was_busy && mode == 2'b10 && hv_en && !prog_n) begin
        if (m_ehold == EC - 1) begin
          for (int i = 0; i < 4096; i++) mm[i] = 8'hFF;
          mknown = 1;
          m_ehold = 0;
        end else m_ehold++;
      end else m_ehold = 0;
      m_prev = prog_n;
    end
  end

  function automatic logic [7:0] exp_dout();
    case (mode)
      2'b00: begin
        if (lock_on) return 8'h00;
        if (m_busy && addr == m_wa) return {~m_wd[7], m_wd[6:0]};
        return mm[addr];
      end
      2'b11: begin
        if (addr == 12'h030) return 8'h1E;
        if (addr == 12'h031) return 8'h51;
        if (addr == 12'h032) return sig_5v ? 8'h05 : 8'hFF;
        return 8'h00;
      end
      default: return 8'h00;
    endcase
  endfunction

  task automatic report(string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t",
               cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      report("ready", {7'b0, ready}, {7'b0, !m_busy});
      report("err", {7'b0, err}, {7'b0, m_err});
      if (mode != 2'b00 || mknown || lock_on) report("dout", dout, exp_dout());
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic strobe_prog(logic [11:0] a, logic [7:0] d, logic hv);
    mode = 2'b01; addr = a; din = d; hv_en = hv;
    tick(1);
    prog_n = 1'b0;
    tick(2);
    prog_n = 1'b1;
    tick(1);
    mode = 2'b00;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    #3 rst_n = 1'b0;
    chk_on = 1;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R9: signature codes
    cur_req = "R9";
    mode = 2'b11;
    addr = 12'h030; tick(1);
    addr = 12'h031; tick(1);
    addr = 12'h032; tick(1);
    sig_5v = 1'b1;  tick(1);
    addr = 12'h033; tick(1);
    sig_5v = 1'b0;

    // R8: full chip erase
    cur_req = "R8";
    mode = 2'b10; hv_en = 1'b1;
    prog_n = 1'b0; tick(EC + 1);
    prog_n = 1'b1; tick(1);
    mode = 2'b00;
    addr = 12'h000; tick(1);
    addr = 12'hFFF; tick(1);

    // R11: no read data in program / erase modes
    cur_req = "R11";
    hv_en = 1'b0;
    mode = 2'b01; tick(2);
    mode = 2'b10; tick(2);
    hv_en = 1'b1;

    // R2 / R4 / R5: byte write, polling, completion
    cur_req = "R2";
    strobe_prog(12'h123, 8'h5A, 1'b1);
    cur_req = "R4";
    addr = 12'h123; tick(5);
    addr = 12'h124; tick(2);
    addr = 12'h123; tick(WC - 8);
    cur_req = "R5";
    tick(4);

    // R3: reprogram non-blank byte only clears bits (5A & F0 = 50)
    cur_req = "R3";
    strobe_prog(12'h123, 8'hF0, 1'b1);
    addr = 12'h123; tick(WC + 3);

    // R4: polling with bit 7 set in the datum
    cur_req = "R4";
    strobe_prog(12'h7FF, 8'h80, 1'b1);
    addr = 12'h7FF; tick(WC + 3);

    // R7: strobe during busy ignored and flagged
    cur_req = "R7";
    strobe_prog(12'h200, 8'h3C, 1'b1);
    mode = 2'b01; addr = 12'h201; din = 8'h00;
    tick(2);
    prog_n = 1'b0; tick(1);
    prog_n = 1'b1; tick(2);
    mode = 2'b00; addr = 12'h200; tick(WC);
    addr = 12'h201; tick(2);

    // R6: strobe without high voltage, and falling edge in verify mode
    cur_req = "R6";
    strobe_prog(12'h300, 8'h00, 1'b0);
    addr = 12'h300; tick(2);
    hv_en = 1'b1;
    prog_n = 1'b0; tick(2);
    prog_n = 1'b1; tick(2);

    // R8: hold shorter than the erase time leaves the array alone
    cur_req = "R8";
    mode = 2'b10; prog_n = 1'b0; tick(EC - 3);
    prog_n = 1'b1; mode = 2'b00; addr = 12'h123; tick(2);
    mode = 2'b10; prog_n = 1'b0; tick(EC + 1);
    prog_n = 1'b1; mode = 2'b00; tick(2);

    // R10: lock inhibits verify read-back
    cur_req = "R10";
    lock_on = 1'b1; addr = 12'h010; tick(2);
    lock_on = 1'b0; tick(2);

    finish_run();
  end

endmodule